// File: doc/BRIEF.md
# Serial-Controlled Clock Output Enable Slave

This block is a two-wire serial slave (SMBus / I2C timing) that holds the enable controls for a bank of clock output pairs. It oversamples the bus clock and data lines with the system clock, detects start and stop conditions, and pulls the data line low through an open-drain enable output. A strap input selects one of two 7-bit addresses so that two parts can share a bus.

The host picks the transfer style in the command byte. In single-byte mode the command carries a 5-bit register offset and a device-select field. In block mode a byte count comes before the data, and transfers always begin at offset 0. Of the 32 offsets, two are implemented. One holds the threshold select, the two feedback disables and one bank-B enable. The other holds the remaining bank enables. The decoded fields drive the enable outputs directly. Every output is enabled after reset.

Top module: `clkbuf_smb_ctrl`

## Requirements
- R1: The slave acknowledges the address byte only when its upper seven bits equal 1101001 (addrSel high, write byte D2h) or 1101110 (addrSel low, write byte DCh). For any other address it leaves SDA released for the rest of that transaction, up to the next start or stop.
- R2: Bytes move most significant bit first. The slave acknowledges by holding SDA low through the ninth clock pulse, and it only starts pulling SDA low while SCL is low.
- R3: After reset the threshold select is 00 and every feedback and pair enable is 1. Offset 22 reads 02h and offset 23 reads ECh.
- R4: A command byte with bit 7 = 1 and bits 6:5 = 01 selects single-byte mode with offset = bits 4:0. A following data byte is written to that offset and acknowledged. Any further data byte in the same transaction is not acknowledged and is discarded.
- R5: A single-byte command whose bits 6:5 differ from 01 is not acknowledged, and no register changes in that transaction.
- R6: A single-byte read (command, repeated start, read address) returns the register at the command's offset. Any extra byte the master clocks out reads as FFh, because SDA is left released.
- R7: A command byte with bit 7 = 0 selects block mode. In a block write the first data byte is the count, and the following bytes are written to offsets 0, 1, 2 and so on. Bytes past the count are not acknowledged and are discarded. A stop after any complete byte keeps the writes made so far.
- R8: A block read returns the count 24 and then the bytes of offsets 0 upward. It keeps sending for as long as the master acknowledges and stops after the master's first non-acknowledge.
- R9: Offset 22 bits 7:6 drive thresholdSel. A 1 in bit 5 clears fbEn[0]. A 1 in bit 4 clears fbEn[1]. Bit 1 drives pairEnB[2].
- R10: Offset 23 bits 7 and 6 drive pairEnB[1] and pairEnB[0]. Bits 5, 3 and 2 drive pairEnA[2], pairEnA[1] and pairEnA[0]. A 1 means active.
- R11: Writes to unimplemented offsets and bits have no effect, and those offsets and bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Address strap; high selects 1101001, low selects 1101110 |
| sdaDrvLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| thresholdSel | output | 2 | Input threshold code |
| fbEn | output | 2 | Feedback clock enables, index 0 first output |
| pairEnA | output | 3 | Bank A pair enables |
| pairEnB | output | 3 | Bank B pair enables |

## Verification
Some properties are checked on every cycle. The slave only begins pulling SDA low while SCL is low. It never drives the line while idle or while ignoring a transaction. A register write strobe appears only during the acknowledge of a data byte. The stored bytes never change without a strobe. The bench scenarios cover the parts that depend on the command sequence: address matching under both strap values, device-select rejection, the count limit and early stop in block writes, block-read ordering, the released extra byte in single-byte reads, and the masking of reserved bits. A behavioural model compares the decoded enables against the DUT outputs on every clock.

// File: rtl/clkbuf_smb_pkg.sv
package clkbuf_smb_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [REG_AW-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [REG_AW-1:0] rdAddr;
  } regStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_WDATA, PH_ACK, PH_TX, PH_MACK, PH_SKIP
  } phase_t;
endpackage

// File: rtl/clkbuf_smb_regs.sv
module clkbuf_smb_regs
  import clkbuf_smb_pkg::*;
#(
  parameter logic [REG_AW-1:0] OFS_CTRL  = 5'd22,
  parameter logic [REG_AW-1:0] OFS_EN    = 5'd23,
  parameter logic [7:0]        DEF_CTRL  = 8'h02,
  parameter logic [7:0]        DEF_EN    = 8'hEC,
  parameter logic [7:0]        MASK_CTRL = 8'hF2,
  parameter logic [7:0]        MASK_EN   = 8'hEC
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strb,
  output logic [7:0]  rdData,
  output logic [1:0]  thresholdSel,
  output logic [1:0]  fbEn,
  output logic [2:0]  pairEnA,
  output logic [2:0]  pairEnB
);
  localparam int NIMPL = 2;
  localparam logic [NIMPL*REG_AW-1:0] OFS_LIST  = {OFS_EN, OFS_CTRL};
  localparam logic [NIMPL*8-1:0]      DEF_LIST  = {DEF_EN, DEF_CTRL};
  localparam logic [NIMPL*8-1:0]      MASK_LIST = {MASK_EN, MASK_CTRL};

  logic [7:0] regQ [NIMPL];

  for (genvar g = 0; g < NIMPL; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= DEF_LIST[g*8 +: 8];
      else if (strb.wrEn && strb.wrAddr == OFS_LIST[g*REG_AW +: REG_AW])
        q <= strb.wrData & MASK_LIST[g*8 +: 8];
    end
    assign regQ[g] = q;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NIMPL; i++)
      if (strb.rdAddr == OFS_LIST[i*REG_AW +: REG_AW]) rdData = regQ[i];
  end

  assign thresholdSel = regQ[0][7:6];
  assign fbEn         = {~regQ[0][4], ~regQ[0][5]};
  assign pairEnB      = {regQ[0][1], regQ[1][7], regQ[1][6]};
  assign pairEnA      = {regQ[1][5], regQ[1][3], regQ[1][2]};

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> ($stable(regQ[0]) && $stable(regQ[1]))); // R11
endmodule

// File: rtl/clkbuf_smb_ctrl_fsm.sv
module clkbuf_smb_ctrl_fsm
  import clkbuf_smb_pkg::*;
#(
  parameter logic [6:0] ADDR_HI     = 7'b1101001,
  parameter logic [6:0] ADDR_LO     = 7'b1101110,
  parameter int         BLK_CNT     = 24,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] rdData,
  output regStrobe_t strb,
  output logic       sdaDrvLow
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startCond, stopCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  phase_t      phase, afterAck;
  logic [3:0]  bitCnt;
  logic [7:0]  shiftIn, txShift, cntLeft, txNext, rxByte;
  logic [4:0]  ptr, cmdOfs;
  logic        isBlock, firstData, ackArmed, mAcked;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [7:0]  wrData;
  logic [6:0]  myAddr;

  assign rxByte = {shiftIn[6:0], sdaS};
  assign myAddr = addrSel ? ADDR_HI : ADDR_LO;

  always_comb begin
    if (isBlock && firstData)       txNext = BLK_CNT[7:0];
    else if (!isBlock && !firstData) txNext = 8'hFF;
    else                             txNext = rdData;
  end

  always_comb begin
    strb.wrEn   = wrEn;
    strb.wrAddr = wrAddr;
    strb.wrData = wrData;
    strb.rdAddr = ptr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; afterAck <= PH_IDLE; bitCnt <= '0;
      shiftIn <= '0; txShift <= '0; cntLeft <= '0;
      ptr <= '0; cmdOfs <= '0; isBlock <= 1'b1; firstData <= 1'b0;
      ackArmed <= 1'b0; mAcked <= 1'b0; sdaDrvLow <= 1'b0;
      wrEn <= 1'b0; wrAddr <= '0; wrData <= '0;
    end else begin
      wrEn <= 1'b0;
      if (startCond) begin
        phase <= PH_ADDR; bitCnt <= '0; sdaDrvLow <= 1'b0;
      end else if (stopCond) begin
        phase <= PH_IDLE; sdaDrvLow <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR, PH_CMD, PH_WDATA: begin
            if (sclRise) begin
              shiftIn <= rxByte;
              bitCnt  <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) begin
                bitCnt   <= '0;
                ackArmed <= 1'b0;
                phase    <= PH_SKIP;
                case (phase)
                  PH_ADDR: if (rxByte[7:1] == myAddr) begin
                    phase <= PH_ACK;
                    if (rxByte[0]) begin
                      afterAck  <= PH_TX;
                      firstData <= 1'b1;
                      ptr       <= isBlock ? 5'd0 : cmdOfs;
                    end else afterAck <= PH_CMD;
                  end
                  PH_CMD: if (!rxByte[7] || rxByte[6:5] == 2'b01) begin
                    phase     <= PH_ACK;
                    afterAck  <= PH_WDATA;
                    isBlock   <= ~rxByte[7];
                    cmdOfs    <= rxByte[4:0];
                    ptr       <= rxByte[7] ? rxByte[4:0] : 5'd0;
                    firstData <= 1'b1;
                  end
                  PH_WDATA: begin
                    afterAck <= PH_WDATA;
                    if (isBlock && firstData) begin
                      cntLeft <= rxByte; firstData <= 1'b0; phase <= PH_ACK;
                    end else if ((isBlock && cntLeft != 8'd0) || (!isBlock && firstData)) begin
                      wrEn <= 1'b1; wrAddr <= ptr; wrData <= rxByte;
                      phase <= PH_ACK; firstData <= 1'b0;
                      if (isBlock) begin
                        ptr <= ptr + 5'd1; cntLeft <= cntLeft - 8'd1;
                      end
                    end
                  end
                  default: ;
                endcase
              end
            end
          end
          PH_ACK: begin
            if (sclFall) begin
              if (!ackArmed) begin
                ackArmed <= 1'b1; sdaDrvLow <= 1'b1;
              end else begin
                ackArmed <= 1'b0; phase <= afterAck; bitCnt <= '0;
                if (afterAck == PH_TX) begin
                  txShift <= txNext; sdaDrvLow <= ~txNext[7]; firstData <= 1'b0;
                  if (isBlock && !firstData) ptr <= ptr + 5'd1;
                end else sdaDrvLow <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaDrvLow <= 1'b0; phase <= PH_MACK; mAcked <= 1'b0;
              end else begin
                txShift <= {txShift[6:0], 1'b0}; sdaDrvLow <= ~txShift[6];
              end
            end
          end
          PH_MACK: begin
            if (sclRise) begin
              if (sdaS) phase <= PH_SKIP;
              else mAcked <= 1'b1;
            end else if (sclFall && mAcked) begin
              phase <= PH_TX; bitCnt <= '0;
              txShift <= txNext; sdaDrvLow <= ~txNext[7]; firstData <= 1'b0;
              if (isBlock && !firstData) ptr <= ptr + 5'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclS); // R2
  AST_QUIET_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE || phase == PH_SKIP) |-> !sdaDrvLow); // R1
  AST_WRITE_IN_DATA_ACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (phase == PH_ACK && afterAck == PH_WDATA)); // R4
  AST_NO_WRITE_WHEN_SKIPPING: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP) |=> !wrEn); // R5
endmodule

// File: rtl/clkbuf_smb_ctrl.sv
module clkbuf_smb_ctrl
  import clkbuf_smb_pkg::*;
#(
  parameter logic [6:0] ADDR_HI     = 7'b1101001,
  parameter logic [6:0] ADDR_LO     = 7'b1101110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  output logic       sdaDrvLow,
  output logic [1:0] thresholdSel,
  output logic [1:0] fbEn,
  output logic [2:0] pairEnA,
  output logic [2:0] pairEnB
);
  localparam logic [4:0] OFS_CTRL = 5'd22;
  localparam logic [4:0] OFS_EN   = 5'd23;
  localparam int         BLK_CNT  = int'(OFS_EN) + 1;

  regStrobe_t strb;
  logic [7:0] rdData;

  clkbuf_smb_ctrl_fsm #(
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO),
    .BLK_CNT(BLK_CNT), .SYNC_STAGES(SYNC_STAGES)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdData(rdData), .strb(strb), .sdaDrvLow(sdaDrvLow)
  );

  clkbuf_smb_regs #(
    .OFS_CTRL(OFS_CTRL), .OFS_EN(OFS_EN)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData),
    .thresholdSel(thresholdSel), .fbEn(fbEn), .pairEnA(pairEnA), .pairEnB(pairEnB)
  );
endmodule

// File: tb/clkbuf_smb_ctrl_tb.sv
module clkbuf_smb_ctrl_tb;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b1;
  logic sdaLine, sdaDrvLow;
  logic [1:0] thresholdSel, fbEn;
  logic [2:0] pairEnA, pairEnB;
  int checks = 0, errors = 0;
  bit hold = 1'b1;
  logic [7:0] mdl [32];

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDrvLow;

  clkbuf_smb_ctrl u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaDrvLow(sdaDrvLow), .thresholdSel(thresholdSel), .fbEn(fbEn),
    .pairEnA(pairEnA), .pairEnB(pairEnB)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input int o);
    return (o == 22) ? 8'hF2 : (o == 23) ? 8'hEC : 8'h00;
  endfunction

  function automatic logic [9:0] expOuts();
    logic [7:0] c, e;
    c = mdl[22]; e = mdl[23];
    return {c[7:6], ~c[4], ~c[5], e[5], e[3], e[2], c[1], e[7], e[6]};
  endfunction

  // per-clock comparison of decoded enables against the model (R9, R10)
  always @(negedge clk)
    if (rstN && !hold)
      chk("R9/R10 monitor", {22'd0, thresholdSel, fbEn, pairEnA, pairEnB}, {22'd0, expOuts()});

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask
  task automatic sendBit(input bit b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic recvBit(output bit b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); b = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask
  task automatic wrByte(input logic [7:0] d, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(r); ack = ~r;
  endtask
  task automatic rdByte(input bit ackIt, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin recvBit(r); d[i] = r; end
    sendBit(~ackIt);
  endtask

  task automatic modelWr(input int o, input logic [7:0] v);
    mdl[o] = v & maskOf(o);
  endtask

  task automatic byteRead(input logic [7:0] aw, input logic [7:0] cmd, output logic [7:0] d);
    bit a;
    busStart(); wrByte(aw, a); chk("R1 addr ack", a, 1);
    wrByte(cmd, a); chk("R4 cmd ack", a, 1);
    busStart(); wrByte(aw | 8'h01, a); chk("R6 read addr ack", a, 1);
    rdByte(1'b0, d); busStop();
  endtask

  task automatic byteWrite(input logic [7:0] aw, input logic [7:0] cmd, input logic [7:0] d,
                           output bit a0, output bit a1, output bit a2);
    hold = 1'b1;
    busStart(); wrByte(aw, a0); wrByte(cmd, a1); wrByte(d, a2); busStop();
  endtask

  task automatic release_hold(); repeat (4) @(negedge clk); hold = 1'b0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit a0, a1, a2;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    mdl[22] = 8'h02; mdl[23] = 8'hEC;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R3 reset state of the outputs
    chk("R3 reset outputs", {22'd0, thresholdSel, fbEn, pairEnA, pairEnB}, {22'd0, 10'b00_11_111_111});
    hold = 1'b0;

    // R3/R6 reset readback of both registers, MSB first (R2)
    byteRead(8'hD2, 8'hB6, d); chk("R3 R6 read ofs22", d, 8'h02);
    byteRead(8'hD2, 8'hB7, d); chk("R3 R6 read ofs23", d, 8'hEC);

    // R4/R10 single-byte write disables all offset-23 pairs
    byteWrite(8'hD2, 8'hB7, 8'h00, a0, a1, a2);
    chk("R4 data ack", a2, 1); modelWr(23, 8'h00); release_hold();
    chk("R10 bank A off", pairEnA, 3'b000);

    // R9/R11 offset 22 all ones; reserved bits read 0
    byteWrite(8'hD2, 8'hB6, 8'hFF, a0, a1, a2);
    chk("R9 write ack", a2, 1); modelWr(22, 8'hFF); release_hold();
    chk("R9 threshold", thresholdSel, 2'b11);
    chk("R9 feedback off", fbEn, 2'b00);
    byteRead(8'hD2, 8'hB6, d); chk("R11 reserved bits zero", d, 8'hF2);

    // R1 wrong address for the strap, then the other strap value
    hold = 1'b1;
    busStart(); wrByte(8'hDC, a0); busStop();
    chk("R1 DCh ignored while addrSel high", a0, 0);
    addrSel = 1'b0;
    busStart(); wrByte(8'hD2, a0); busStop();
    chk("R1 D2h ignored while addrSel low", a0, 0);
    byteWrite(8'hDC, 8'hB7, 8'h44, a0, a1, a2);
    chk("R1 DCh acked while addrSel low", a0, 1); modelWr(23, 8'h44); release_hold();
    chk("R10 pair enables", {pairEnB, pairEnA}, {3'b101, 3'b001});

    // R5 bad device-select field
    byteWrite(8'hDC, 8'h97, 8'hEC, a0, a1, a2);
    chk("R5 cmd nack", a1, 0); chk("R5 data nack", a2, 0); release_hold();
    chk("R5 no change", pairEnA, 3'b001);

    // R4 second data byte in single-byte mode is refused
    hold = 1'b1;
    busStart(); wrByte(8'hDC, a0); wrByte(8'hB7, a1); wrByte(8'hEC, a2);
    chk("R4 first data ack", a2, 1);
    wrByte(8'h00, a2); chk("R4 extra byte nack", a2, 0);
    busStop(); modelWr(23, 8'hEC); release_hold();
    chk("R4 extra byte discarded", pairEnA, 3'b111);

    // R11 unimplemented offset
    byteWrite(8'hDC, 8'hA5, 8'hAA, a0, a1, a2);
    chk("R11 write acked", a2, 1); release_hold();
    byteRead(8'hDC, 8'hA5, d); chk("R11 unimplemented reads 0", d, 8'h00);

    // R7 block write with count 24 and one excess byte
    hold = 1'b1;
    busStart(); wrByte(8'hDC, a0); wrByte(8'h00, a1); chk("R7 block cmd ack", a1, 1);
    wrByte(8'd24, a2); chk("R7 count ack", a2, 1);
    for (int i = 0; i < 24; i++) begin
      d = (i == 22) ? 8'h40 : (i == 23) ? 8'hA8 : 8'hFF;
      wrByte(d, a2); chk("R7 block data ack", a2, 1); modelWr(i, d);
    end
    wrByte(8'h00, a2); chk("R7 past-count nack", a2, 0);
    busStop(); release_hold();
    chk("R7 R9 R10 outputs", {22'd0, thresholdSel, fbEn, pairEnA, pairEnB},
        {22'd0, 10'b01_11_110_010});

    // R7 stop after 23 bytes keeps offset 22, leaves 23
    hold = 1'b1;
    busStart(); wrByte(8'hDC, a0); wrByte(8'h00, a1); wrByte(8'd24, a2);
    for (int i = 0; i < 23; i++) begin
      d = (i == 22) ? 8'h82 : 8'h00;
      wrByte(d, a2); modelWr(i, d);
    end
    busStop(); release_hold();
    chk("R7 early stop threshold", thresholdSel, 2'b10);
    chk("R7 early stop ofs23 kept", pairEnA, 3'b110);

    // R8 block read
    busStart(); wrByte(8'hDC, a0); wrByte(8'h00, a1);
    busStart(); wrByte(8'hDD, a2); chk("R8 read addr ack", a2, 1);
    rdByte(1'b1, d); chk("R8 byte count", d, 8'd24);
    for (int i = 0; i < 24; i++) begin
      rdByte(i != 23, d); chk("R8 block data", d, mdl[i]);
    end
    busStop();

    // R6 extra byte after single-byte read is released
    busStart(); wrByte(8'hDC, a0); wrByte(8'hB7, a1);
    busStart(); wrByte(8'hDD, a2);
    rdByte(1'b1, d); chk("R6 single byte", d, 8'hA8);
    rdByte(1'b0, d); chk("R6 extra byte released", d, 8'hFF);
    busStop();

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule